// File: doc/BRIEF.md
# Software Store/Recall Command Detector

This block sits on the asynchronous-style memory bus of a nonvolatile SRAM. It samples the bus synchronously on every clock. It watches for a fixed chain of six read cycles at set addresses. When the chain is complete, it starts a nonvolatile transfer: a STORE, which moves SRAM contents into the nonvolatile cells, or a RECALL, which moves them back. The first five addresses of the chain are the same for both commands. The sixth address chooses which command runs.

A command is issued as a one-cycle start pulse. The pulse is followed by a busy window whose length, in clock cycles, is set by a parameter for each command. During the busy window the block holds the chip enable toward the memory array inactive, so reads and writes do not reach the array. Bus reads in that window are also kept out of command tracking. The tracker has named states: `T_IDLE`, then `T_HAVE1` to `T_HAVE5`, one for each address matched so far.

The tracker moves as follows:
- A read at the next expected address advances it one state.
- A read at any other address returns it to `T_IDLE`. This transition is named *mismatch*.
- A write cycle returns it to `T_IDLE`. This transition is named *abort*.
- Busy being high returns it to `T_IDLE`. This transition is named *hold*.
- From `T_HAVE5`, a read at the store key or the recall key fires the command. The tracker returns to `T_IDLE` in either case.

The timer has three states: `B_READY`, `B_STORE` and `B_RECALL`. *Launch* moves it out of `B_READY`. When its count runs out, *expire* returns it to `B_READY`.

Top module: `nv_soft_seq_det`

## Requirements
- R1: After reset, `store_go`, `recall_go` and `busy` are 0, and `mem_ce_n_o` equals `ce_n`.
- R2: Six read cycles at key addresses 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F, 0x8FC0, in this order, raise `store_go` for exactly one cycle. The pulse appears in the clock cycle after the edge that sampled the start of the sixth read.
- R3: The same first five reads followed by a read at 0x4C63 raise `recall_go` for exactly one cycle, with the same timing as R2.
- R4: Only address bits 15:0 are compared. Bit 16 has no effect on matching.
- R5: A read at an address other than the next expected key returns the tracker to idle. The chain must then restart from its first key.
- R6: A write cycle aborts a partial chain. A write cycle is `ce_n`=0 with `we_n`=0, and this includes a cycle where `oe_n` is also 0. After an abort the chain must restart.
- R7: `busy` rises together with the start pulse. It stays high for exactly `STORE_CYC` cycles (default 40) after a STORE, or `RECALL_CYC` cycles (default 24) after a RECALL, and then falls.
- R8: While `busy` is high, `mem_ce_n_o` is 1 whatever the value of `ce_n`.
- R9: Reads that occur while `busy` is high are not tracked. A chain sent during busy leaves the tracker idle once busy ends.
- R10: A read is counted once, at the first clock where `ce_n`=0, `oe_n`=0 and `we_n`=1 after a clock where that condition was false. Changing the address while the read stays active does not count as a new read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for sampling and timing |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 17 | Memory bus address |
| ce_n | input | 1 | Active-low chip enable from the bus |
| oe_n | input | 1 | Active-low output enable from the bus |
| we_n | input | 1 | Active-low write enable from the bus |
| store_go | output | 1 | One-cycle STORE start pulse |
| recall_go | output | 1 | One-cycle RECALL start pulse |
| busy | output | 1 | High while a transfer is in progress |
| mem_ce_n_o | output | 1 | Chip enable toward the array, forced inactive while busy |

## Verification
Directed chains are sent for STORE, for RECALL, and for both with address bit 16 set. These show that the sixth key alone decides the command and that the top address bit is ignored. Chains broken by a stray read, by a write, by a read with write enable low, and by an address change inside a held read each separate a true restart from a tracker that skips or double-counts reads. Random traffic mixes correct next keys, random addresses and writes, and is checked against a step model. After each command, the busy length and the gating of chip enable are measured, so STORE and RECALL timing can be told apart.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
    typedef enum logic [2:0] {
        T_IDLE,
        T_HAVE1,
        T_HAVE2,
        T_HAVE3,
        T_HAVE4,
        T_HAVE5
    } trk_state_t;

    typedef enum logic [1:0] {
        B_READY,
        B_STORE,
        B_RECALL
    } bsy_state_t;
endpackage

// File: rtl/nvseq_edge.sv
module nvseq_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic rd_start,
    output logic wr_start
);
    logic rd_act;
    logic wr_act;
    logic rd_prev;
    logic wr_prev;

    assign rd_act = !ce_n && !oe_n && we_n;
    assign wr_act = !ce_n && !we_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prev <= 1'b0;
            wr_prev <= 1'b0;
        end else begin
            rd_prev <= rd_act;
            wr_prev <= wr_act;
        end
    end

    // a new cycle only on the first clock of an active phase
    assign rd_start = rd_act && !rd_prev;
    assign wr_start = wr_act && !wr_prev;
endmodule

// File: rtl/nvseq_track.sv
module nvseq_track
    import nvseq_pkg::*;
#(
    parameter int unsigned KEY_W = 16,
    parameter logic [KEY_W-1:0] KEY0 = 16'h4E38,
    parameter logic [KEY_W-1:0] KEY1 = 16'hB1C7,
    parameter logic [KEY_W-1:0] KEY2 = 16'h83E0,
    parameter logic [KEY_W-1:0] KEY3 = 16'h7C1F,
    parameter logic [KEY_W-1:0] KEY4 = 16'h703F,
    parameter logic [KEY_W-1:0] KEY_ST = 16'h8FC0,
    parameter logic [KEY_W-1:0] KEY_RC = 16'h4C63
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_start,
    input  logic             wr_start,
    input  logic             hold,
    input  logic [KEY_W-1:0] key,
    output logic             hit_store,
    output logic             hit_recall
);
    trk_state_t state;
    trk_state_t nxt;
    logic [KEY_W-1:0] want;
    logic match;

    always_comb begin
        unique case (state)
            T_IDLE:  want = KEY0;
            T_HAVE1: want = KEY1;
            T_HAVE2: want = KEY2;
            T_HAVE3: want = KEY3;
            T_HAVE4: want = KEY4;
            default: want = '0;
        endcase
    end

    assign match = rd_start && (key == want) && (state != T_HAVE5);

    // next state: hold, abort, advance, mismatch
    always_comb begin
        nxt = state;
        if (hold || wr_start) begin
            nxt = T_IDLE;
        end else if (rd_start) begin
            unique case (state)
                T_IDLE:  nxt = match ? T_HAVE1 : T_IDLE;
                T_HAVE1: nxt = match ? T_HAVE2 : T_IDLE;
                T_HAVE2: nxt = match ? T_HAVE3 : T_IDLE;
                T_HAVE3: nxt = match ? T_HAVE4 : T_IDLE;
                T_HAVE4: nxt = match ? T_HAVE5 : T_IDLE;
                T_HAVE5: nxt = T_IDLE;
                default: nxt = T_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= T_IDLE;
        else        state <= nxt;
    end

    // outputs: command hits from the last chain state
    always_comb begin
        hit_store  = 1'b0;
        hit_recall = 1'b0;
        if (!hold && !wr_start && rd_start && state == T_HAVE5) begin
            hit_store  = (key == KEY_ST);
            hit_recall = (key == KEY_RC);
        end
    end

    p_abort_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |=> state == T_IDLE);
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> state == T_IDLE);
    p_hit_from_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_store || hit_recall) |=> state == T_IDLE);
endmodule

// File: rtl/nvseq_busy.sv
module nvseq_busy
    import nvseq_pkg::*;
#(
    parameter int unsigned STORE_CYC  = 40,
    parameter int unsigned RECALL_CYC = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_store,
    input  logic hit_recall,
    output logic store_go,
    output logic recall_go,
    output logic busy
);
    localparam int unsigned MAXC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int unsigned CW   = $clog2(MAXC + 1);

    bsy_state_t      state;
    logic [CW-1:0]   cnt;

    // state register with launch and expire
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= B_READY;
            cnt   <= '0;
        end else begin
            unique case (state)
                B_READY: begin
                    if (hit_store) begin
                        state <= B_STORE;
                        cnt   <= CW'(STORE_CYC - 1);
                    end else if (hit_recall) begin
                        state <= B_RECALL;
                        cnt   <= CW'(RECALL_CYC - 1);
                    end
                end
                B_STORE, B_RECALL: begin
                    if (cnt == '0) state <= B_READY;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= B_READY;
            endcase
        end
    end

    // output register: start pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_go  <= 1'b0;
            recall_go <= 1'b0;
        end else begin
            store_go  <= hit_store && (state == B_READY);
            recall_go <= hit_recall && !hit_store && (state == B_READY);
        end
    end

    assign busy = (state != B_READY);

    p_one_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_go, recall_go}));
    p_go_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (store_go || recall_go) |-> busy);
    p_busy_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (store_go || recall_go));
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == B_RECALL) |-> (cnt < CW'(RECALL_CYC)));
endmodule

// File: rtl/nv_soft_seq_det.sv
module nv_soft_seq_det #(
    parameter int unsigned ADDR_W     = 17,
    parameter int unsigned KEY_W      = 16,
    parameter int unsigned STORE_CYC  = 40,
    parameter int unsigned RECALL_CYC = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    output logic              store_go,
    output logic              recall_go,
    output logic              busy,
    output logic              mem_ce_n_o
);
    logic rd_start;
    logic wr_start;
    logic hit_store;
    logic hit_recall;
    logic addr_hi_unused;

    generate
        if (ADDR_W > KEY_W) begin : g_hi
            assign addr_hi_unused = ^addr[ADDR_W-1:KEY_W];
        end else begin : g_nohi
            assign addr_hi_unused = 1'b0;
        end
    endgenerate

    nvseq_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .we_n     (we_n),
        .rd_start (rd_start),
        .wr_start (wr_start)
    );

    nvseq_track #(.KEY_W(KEY_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_start   (rd_start),
        .wr_start   (wr_start),
        .hold       (busy),
        .key        (addr[KEY_W-1:0]),
        .hit_store  (hit_store),
        .hit_recall (hit_recall)
    );

    nvseq_busy #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_busy (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_store  (hit_store),
        .hit_recall (hit_recall),
        .store_go   (store_go),
        .recall_go  (recall_go),
        .busy       (busy)
    );

    assign mem_ce_n_o = ce_n || busy;

    p_no_go_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_start && !busy) |=> !(store_go || recall_go));
endmodule

// File: tb/test_nv_soft_seq_det.sv
`timescale 1ns/1ps
module test_nv_soft_seq_det;
    localparam int STORE_CYC  = 40;
    localparam int RECALL_CYC = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [16:0] addr = '0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic        store_go, recall_go, busy, mem_ce_n_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nv_soft_seq_det #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) i_nv_soft_seq_det (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .store_go(store_go), .recall_go(recall_go), .busy(busy), .mem_ce_n_o(mem_ce_n_o)
    );

    function automatic logic [15:0] key_of(int step, bit rc);
        case (step)
            0: return 16'h4E38;
            1: return 16'hB1C7;
            2: return 16'h83E0;
            3: return 16'h7C1F;
            4: return 16'h703F;
            default: return rc ? 16'h4C63 : 16'h8FC0;
        endcase
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic rd(logic [16:0] a);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic wr(logic [16:0] a, bit oe_low);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = !oe_low; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic first_five(bit hi);
        for (int i = 0; i < 5; i++) rd({hi, key_of(i, 1'b0)});
    endtask

    task automatic measure_busy(output int len);
        len = 0;
        while (busy && len < 1000) begin
            len++;
            @(negedge clk);
        end
    endtask

    task automatic expect_cmd(bit rc, string req);
        int len;
        chk(store_go == !rc, req, store_go, !rc);
        chk(recall_go == rc, req, recall_go, rc);
        measure_busy(len);
        chk(len == (rc ? RECALL_CYC : STORE_CYC), "R7", len, rc ? RECALL_CYC : STORE_CYC);
    endtask

    task automatic expect_none(string req);
        chk(!store_go && !recall_go && !busy, req, {store_go, recall_go, busy}, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog act=1 exp=0");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int len;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_none("R1");
        chk(mem_ce_n_o == 1'b1, "R1", mem_ce_n_o, 1);
        ce_n = 1'b0; #1;
        chk(mem_ce_n_o == 1'b0, "R1", mem_ce_n_o, 0);
        ce_n = 1'b1;

        // R2 store chain
        first_five(1'b0); rd({1'b0, key_of(5, 1'b0)});
        chk(busy == 1'b1, "R7", busy, 1);
        @(negedge clk);
        chk(store_go == 1'b0, "R2", store_go, 0);
        // R8 gating while busy
        ce_n = 1'b0; #1;
        chk(mem_ce_n_o == 1'b1, "R8", mem_ce_n_o, 1);
        measure_busy(len);
        chk(len == STORE_CYC - 1, "R7", len, STORE_CYC - 1);
        #1;
        chk(mem_ce_n_o == 1'b0, "R8", mem_ce_n_o, 0);
        ce_n = 1'b1;

        // R3 recall chain
        first_five(1'b0); rd({1'b0, key_of(5, 1'b1)});
        expect_cmd(1'b1, "R3");
        // R4 bit 16 set
        first_five(1'b1); rd({1'b1, key_of(5, 1'b0)});
        expect_cmd(1'b0, "R4");
        first_five(1'b1); rd({1'b1, key_of(5, 1'b1)});
        expect_cmd(1'b1, "R4");

        // R5 stray read mid chain, then the rest
        rd(17'h04E38); rd(17'h0B1C7); rd(17'h01234);
        for (int i = 2; i < 6; i++) rd({1'b0, key_of(i, 1'b0)});
        expect_none("R5");
        // stray read that then restarts fully works
        rd(17'h04E38); rd(17'h05555); first_five(1'b0); rd({1'b0, key_of(5, 1'b0)});
        expect_cmd(1'b0, "R5");
        // wrong sixth key
        first_five(1'b0); rd(17'h0FFFF);
        expect_none("R5");

        // R6 write abort, and read with we low
        rd(17'h04E38); rd(17'h0B1C7); rd(17'h083E0); wr(17'h00000, 1'b0);
        rd(17'h07C1F); rd(17'h0703F); rd(17'h08FC0);
        expect_none("R6");
        rd(17'h04E38); rd(17'h0B1C7); wr(17'h083E0, 1'b1);
        for (int i = 2; i < 6; i++) rd({1'b0, key_of(i, 1'b1)});
        expect_none("R6");

        // R10 address change inside a held read
        @(negedge clk);
        addr = 17'h04E38; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk); addr = 17'h0B1C7;
        @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
        for (int i = 2; i < 6; i++) rd({1'b0, key_of(i, 1'b0)});
        expect_none("R10");

        // R9 chain during busy is ignored
        first_five(1'b0); rd({1'b0, key_of(5, 1'b0)});
        chk(store_go == 1'b1, "R2", store_go, 1);
        first_five(1'b0);
        measure_busy(len);
        rd({1'b0, key_of(5, 1'b0)});
        expect_none("R9");

        // random traffic against a step model
        begin
            int step = 0;
            for (int k = 0; k < 300; k++) begin
                int op = $urandom % 10;
                bit hi = $urandom % 2;
                bit rc = $urandom % 2;
                logic [15:0] a;
                bit exp_s = 0, exp_r = 0;
                if (op < 7) begin
                    a = (op < 5) ? key_of(step, rc) : 16'($urandom);
                    rd({hi, a});
                    if (step == 5) begin
                        exp_s = (a == key_of(5, 1'b0));
                        exp_r = (a == key_of(5, 1'b1));
                        step = 0;
                    end else if (a == key_of(step, 1'b0)) step++;
                    else step = 0;
                end else begin
                    wr({hi, 16'($urandom)}, op == 9);
                    step = 0;
                end
                if (exp_s || exp_r) expect_cmd(exp_r, "R2");
                else expect_none("R5");
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule